// File: doc/BRIEF.md
# Data Address Watchpoint Unit

This block watches the stream of data loads and stores issued by a processor core and raises a debug request when an access falls inside a watched region. It has two independent channels. Each channel holds a base address and a control word. The control word chooses whether loads, stores or both trigger the channel. Its low six bits form a compare mask that sets the size of the watched window, which is a naturally aligned power-of-two window from 1 to 64 bytes.

Software programs the channels through a simple write port. Each write selects a channel and one of its two registers. The core presents one access per cycle on the access bus. When a channel matches, the block registers a debug request and a cause word on the next clock edge. The cause word has a data-break flag and a bit that identifies the firing channel. Both stay held until the handler pulses the clear input.

Top module: `dwatch_unit`

## Requirements
- R1: After a synchronous active-low reset, `dbg_req` is 0, `dbg_cause` is 0, and both channels are disabled, so no access triggers.
- R2: Control bit 30 enables matching on loads. Control bit 31 enables matching on stores. With both set, either access type matches.
- R3: Control bits 5:0 are the compare mask. An address bit whose mask bit is 0 is not compared. Mask 0x3F watches one byte, 0x38 watches 8 bytes, and 0x00 watches 64 bytes.
- R4: Address bits 31:6 are always compared exactly. A base address that is not aligned to the window size watches the aligned window that contains it.
- R5: A control value of zero disables the channel.
- R6: On a match, `dbg_cause` bit 2 (data break) is 1. `dbg_cause` bit 8 is 1 when channel 1 fired and 0 when channel 0 fired. All other cause bits are 0.
- R7: When both channels match the same access, channel 0 is reported, so cause bit 8 is 0.
- R8: `dbg_req` and `dbg_cause` change on the clock edge that samples the matching access. They then hold unchanged until `cause_clr` is asserted, and later matches do not alter them.
- R9: `cause_clr` with no match in the same cycle returns `dbg_req` and `dbg_cause` to 0 at the next edge. If a match coincides with `cause_clr`, the new cause is captured instead.
- R10: Control bits 29:6 are reserved, and writing them has no effect on matching.
- R11: A register write takes effect from the next cycle. An access in the same cycle as a write is compared against the old values.
- R12: An access with `acc_valid` low never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 1 | Channel selected for the write |
| cfg_sel | input | 1 | 0 writes the base address, 1 writes the control word |
| cfg_wdata | input | 32 | Write data |
| acc_valid | input | 1 | Access bus carries an access this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_load | input | 1 | Access is a load |
| acc_store | input | 1 | Access is a store |
| cause_clr | input | 1 | Clears the held request and cause |
| dbg_req | output | 1 | Debug exception request |
| dbg_cause | output | 32 | Cause word: bit 2 data break, bit 8 channel 1 |

## Verification
Two pairs of functions can act in the same cycle. A clear and a fresh match can coincide, and a register write and an access can coincide. The bench drives `cause_clr` in the same cycle as an access that hits channel 1, and expects the new cause rather than zero. It also writes a channel's control word in the same cycle as an access that only the new value would match, and expects no trigger until the following cycle. A behavioural model in the bench tracks both channels and the held cause. Every clock edge is judged against that model.

// File: rtl/dwatch_pkg.sv
// Shared constants and types for the data watchpoint unit.
// Assumes a 32-bit byte-addressed access bus and a 32-bit control word.
package dwatch_pkg;
    localparam int ADDR_W         = 32;
    localparam int DATA_W         = 32;
    localparam int NUM_CH         = 2;
    localparam int CH_W           = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int MASK_W         = 6;
    localparam int LOAD_BIT       = 30;
    localparam int STORE_BIT      = 31;
    localparam int CAUSE_DBRK_BIT = 2;
    localparam int CAUSE_CH_BIT   = 8;

    // Live state of one channel; reserved control bits are not stored.
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic              store_en;
        logic              load_en;
        logic [MASK_W-1:0] mask;
    } chan_cfg_t;
endpackage

// File: rtl/dwatch_chan_regs.sv
// Register pair (base address, control) of one watchpoint channel.
// Assumes writes are single-cycle strobes; only enable and mask bits are kept.
module dwatch_chan_regs
    import dwatch_pkg::*;
#(
    parameter int CH_ID = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CH_W-1:0]      cfg_ch,
    input  logic                 cfg_sel,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output chan_cfg_t            cfg
);
    logic hit_this;
    assign hit_this = cfg_we && (cfg_ch == CH_W'(CH_ID));

    // Capture base or control on a write addressed to this channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (hit_this) begin
            if (cfg_sel) begin
                cfg.store_en <= cfg_wdata[STORE_BIT];
                cfg.load_en  <= cfg_wdata[LOAD_BIT];
                cfg.mask     <= cfg_wdata[MASK_W-1:0];
            end else begin
                cfg.base <= cfg_wdata[ADDR_W-1:0];
            end
        end
    end

    // A control write with no enable bits leaves the channel off next cycle.
    assert_ctrl_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_this && cfg_sel && cfg_wdata[STORE_BIT:LOAD_BIT] == 2'b00)
        |=> (!cfg.load_en && !cfg.store_en));
endmodule

// File: rtl/dwatch_chan_match.sv
// Compares one access against one channel's window and enabled access types.
// Assumes address bits above the mask width are always compared.
module dwatch_chan_match
    import dwatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  chan_cfg_t         cfg,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_load,
    input  logic              acc_store,
    output logic              hit
);
    logic [ADDR_W-1:0] cmp_mask;
    logic              addr_eq;
    logic              type_ok;

    // Build the compare mask, then check address and access type.
    always_comb begin
        cmp_mask = {{(ADDR_W-MASK_W){1'b1}}, cfg.mask};
        addr_eq  = ((acc_addr ^ cfg.base) & cmp_mask) == '0;
        type_ok  = (acc_load && cfg.load_en) || (acc_store && cfg.store_en);
        hit      = acc_valid && type_ok && addr_eq;
    end

    assert_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.load_en && !cfg.store_en) |-> !hit);
    assert_invalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !hit);
    assert_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr[ADDR_W-1:MASK_W] != cfg.base[ADDR_W-1:MASK_W]) |-> !hit);
endmodule

// File: rtl/dwatch_cause_reg.sv
// Picks the lowest-numbered firing channel and holds request and cause.
// Assumes a clear coinciding with a match loads the new cause.
module dwatch_cause_reg
    import dwatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit,
    input  logic              cause_clr,
    output logic              dbg_req,
    output logic [DATA_W-1:0] dbg_cause
);
    logic [CH_W-1:0]   win_ch;
    logic [DATA_W-1:0] new_cause;
    logic              any_hit;

    // Lowest index wins: scan from the top so channel 0 overrides.
    always_comb begin
        win_ch = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (hit[i]) win_ch = CH_W'(i);
        end
        any_hit   = |hit;
        new_cause = '0;
        new_cause[CAUSE_DBRK_BIT] = 1'b1;
        new_cause[CAUSE_CH_BIT +: CH_W] = win_ch;
    end

    // Load on a hit when idle or clearing; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_req   <= 1'b0;
            dbg_cause <= '0;
        end else if (cause_clr || !dbg_req) begin
            dbg_req   <= any_hit;
            dbg_cause <= any_hit ? new_cause : '0;
        end
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && !cause_clr) |=> (dbg_req && $stable(dbg_cause)));
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_clr && !any_hit) |=> (!dbg_req && dbg_cause == '0));
    assert_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && (cause_clr || !dbg_req)) |=> (dbg_req && !dbg_cause[CAUSE_CH_BIT]));
    assert_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> dbg_cause[CAUSE_DBRK_BIT]);
endmodule

// File: rtl/dwatch_unit.sv
// Two-channel data address watchpoint: register file, comparators, cause.
// Assumes one access per cycle and single-cycle register write strobes.
module dwatch_unit
    import dwatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_ch,
    input  logic              cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              acc_valid,
    input  logic [31:0]       acc_addr,
    input  logic              acc_load,
    input  logic              acc_store,
    input  logic              cause_clr,
    output logic              dbg_req,
    output logic [31:0]       dbg_cause
);
    chan_cfg_t         cfg_q [NUM_CH];
    logic [NUM_CH-1:0] hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dwatch_chan_regs #(.CH_ID(c)) regs_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we),
            .cfg_ch    (cfg_ch),
            .cfg_sel   (cfg_sel),
            .cfg_wdata (cfg_wdata),
            .cfg       (cfg_q[c])
        );
        dwatch_chan_match match_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg       (cfg_q[c]),
            .acc_valid (acc_valid),
            .acc_addr  (acc_addr),
            .acc_load  (acc_load),
            .acc_store (acc_store),
            .hit       (hit[c])
        );
    end

    dwatch_cause_reg cause_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .cause_clr (cause_clr),
        .dbg_req   (dbg_req),
        .dbg_cause (dbg_cause)
    );

    assert_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!dbg_req && dbg_cause == 32'h0));
endmodule

// File: tb/dwatch_unit_tb_top.sv
`timescale 1ns/1ps
module dwatch_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_ch = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0, acc_load = 1'b0, acc_store = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        cause_clr = 1'b0;
    logic        dbg_req;
    logic [31:0] dbg_cause;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Behavioural model state
    logic [31:0] m_base [2];
    logic [31:0] m_ctrl [2];
    logic        m_req;
    logic [31:0] m_cause;

    always #2.5 clk = ~clk;

    dwatch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_load(acc_load), .acc_store(acc_store),
        .cause_clr(cause_clr), .dbg_req(dbg_req), .dbg_cause(dbg_cause)
    );

    function automatic bit m_hit(int c);
        bit tok;
        logic [31:0] cm;
        if (!acc_valid) return 1'b0;
        tok = (acc_load && m_ctrl[c][30]) || (acc_store && m_ctrl[c][31]);
        cm  = {26'h3FFFFFF, m_ctrl[c][5:0]};
        return tok && (((acc_addr ^ m_base[c]) & cm) == 32'h0);
    endfunction

    // One clock: predict from current inputs, step, then compare outputs.
    task automatic tick(input string tag);
        bit h0, h1;
        logic        n_req;
        logic [31:0] n_cause;
        h0 = m_hit(0);
        h1 = m_hit(1);
        n_req = m_req;
        n_cause = m_cause;
        if (cause_clr || !m_req) begin
            n_req = h0 || h1;
            n_cause = h0 ? 32'h4 : (h1 ? 32'h104 : 32'h0);
        end
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_req = 0; m_cause = 0;
            m_base[0] = 0; m_base[1] = 0; m_ctrl[0] = 0; m_ctrl[1] = 0;
        end else begin
            m_req = n_req;
            m_cause = n_cause;
            if (cfg_we) begin
                if (cfg_sel) m_ctrl[cfg_ch] = cfg_wdata & 32'hC000003F;
                else         m_base[cfg_ch] = cfg_wdata;
            end
        end
        total++;
        if (dbg_req !== m_req) begin
            bad++;
            $display("FAIL %s dbg_req actual=%0b expected=%0b", tag, dbg_req, m_req);
        end
        total++;
        if (dbg_cause !== m_cause) begin
            bad++;
            $display("FAIL %s dbg_cause actual=%h expected=%h", tag, dbg_cause, m_cause);
        end
    endtask

    task automatic wr(input bit ch, input bit sel, input logic [31:0] d, input string tag);
        cfg_we = 1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = d;
        tick(tag);
        cfg_we = 0;
    endtask

    task automatic acc(input logic [31:0] a, input bit ld, input bit st, input string tag);
        acc_valid = 1; acc_addr = a; acc_load = ld; acc_store = st;
        tick(tag);
        acc_valid = 0; acc_load = 0; acc_store = 0;
    endtask

    task automatic clr(input string tag);
        cause_clr = 1;
        tick(tag);
        cause_clr = 0;
    endtask

    initial begin
        #500000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_req = 0; m_cause = 0;
        m_base[0] = 0; m_base[1] = 0; m_ctrl[0] = 0; m_ctrl[1] = 0;
        #1;
        tick("R1"); tick("R1");
        rst_n = 1;
        tick("R1");
        acc(32'h0, 1, 1, "R1");                 // disabled after reset
        // R2: load-only channel 0, one byte
        wr(0, 0, 32'h0000_1000, "R2");
        wr(0, 1, 32'h4000_003F, "R2");
        acc(32'h1000, 0, 1, "R2");              // store ignored
        acc(32'h1000, 1, 0, "R2");              // load fires
        clr("R9");
        acc(32'h1001, 1, 0, "R3");              // outside 1-byte window
        // R2: store-only, then both
        wr(0, 1, 32'h8000_003F, "R2");
        acc(32'h1000, 1, 0, "R2");
        acc(32'h1000, 0, 1, "R2");
        clr("R9");
        // R3: 8-byte window
        wr(0, 1, 32'hC000_0038, "R3");
        acc(32'h1007, 1, 0, "R3");
        clr("R9");
        acc(32'h1008, 0, 1, "R3");
        // R3/R4: 64-byte window, upper bits exact
        wr(0, 1, 32'hC000_0000, "R3");
        acc(32'h103F, 0, 1, "R3");
        clr("R9");
        acc(32'h1040, 1, 0, "R4");
        acc(32'h2000, 1, 0, "R4");
        // R4: unaligned base, 4-byte window
        wr(0, 0, 32'h0000_1005, "R4");
        wr(0, 1, 32'hC000_003C, "R4");
        acc(32'h1004, 1, 0, "R4");
        clr("R9");
        acc(32'h1008, 1, 0, "R4");
        // R12: valid low
        acc_valid = 0; acc_addr = 32'h1004; acc_load = 1; acc_store = 1;
        tick("R12");
        acc_load = 0; acc_store = 0;
        // R5: control zero
        wr(0, 1, 32'h0, "R5");
        acc(32'h1004, 1, 1, "R5");
        // R10: reserved bits only, then reserved plus load
        wr(0, 0, 32'h0000_2000, "R10");
        wr(0, 1, 32'h3FFF_FFC0, "R10");
        acc(32'h2000, 1, 1, "R10");
        wr(0, 1, 32'h7FFF_FFFF, "R10");
        acc(32'h2000, 0, 1, "R10");
        acc(32'h2000, 1, 0, "R10");
        clr("R9");
        // R6: channel 1 fires
        wr(1, 0, 32'h0000_2000, "R6");
        wr(1, 1, 32'hC000_0030, "R6");
        wr(0, 1, 32'h0, "R6");
        acc(32'h200F, 0, 1, "R6");
        // R8: held across later hit and idle cycles
        wr(0, 1, 32'hC000_003F, "R8");
        acc(32'h2000, 1, 0, "R8");
        tick("R8"); tick("R8");
        // R9: clear coinciding with channel 1 hit
        cause_clr = 1;
        acc(32'h2008, 1, 0, "R9");
        cause_clr = 0;
        clr("R9");
        // R7: both match, channel 0 reported
        acc(32'h2000, 0, 1, "R7");
        clr("R9");
        // R11: write coinciding with access uses old values
        wr(1, 1, 32'h0, "R11");
        cfg_we = 1; cfg_ch = 1; cfg_sel = 1; cfg_wdata = 32'hC000_0000;
        acc_valid = 1; acc_addr = 32'h2020; acc_load = 1;
        tick("R11");
        cfg_we = 0;
        tick("R11");                            // new value now applies
        acc_valid = 0; acc_load = 0;
        tick("R11");
        // R1: reset mid-run clears held cause
        rst_n = 0;
        tick("R1");
        rst_n = 1;
        acc(32'h2000, 1, 1, "R1");
        tick("R1");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule